// File: doc/BRIEF.md
# Byte-Command JTAG Pin Driver

The block sits between a byte stream and a JTAG header. It has no notion of the test access port state machine. The host drives TCK, TMS and TDI one snapshot at a time. Each accepted command byte either sets the three output pins, asks for a sample of TDO, or reconfigures the block. A sample request produces exactly one response byte on an outbound valid/ready interface. No further byte is taken until that response has been consumed, so at most one read is ever in flight.

Each write snapshot is held for a programmable number of system clocks before the next byte can be taken. This keeps the TCK rate within the target's setup and hold limits. TDO passes through a two-stage synchronizer before it is sampled.

The bit positions of the three pin fields and of the request flag can be moved at run time. This lets one host encoding serve headers with different pinouts.

Top module: `jtag_byte_driver`

## Requirements
- R1: After reset TCK is low, TMS is high, TDI is low, no response is pending, and `in_ready` is high.
- R2: A byte with bit 7 clear and the request flag clear is a write. With the default map, bit 0 drives TMS, bit 1 drives TDI and bit 3 drives TCK. Bits 6..4 and any unmapped bit are ignored. Pins change in the clock after acceptance and otherwise stay stable.
- R3: A byte with bit 7 clear and the request flag set (default position bit 2) is a read. Its other bits are ignored and the pins do not change. One response byte follows, with the sampled TDO in bit 2 and all other bits 0.
- R4: While a response is pending, `in_ready` is low and `out_data` holds steady until `out_ready` takes it.
- R5: Write and read bytes may be interleaved in any order in one stream. Each read reports TDO as it stood at that point of the stream.
- R6: A byte with bit 7 set is a configuration command. Bits 6..4 select the target: 0 = TMS position, 1 = TDI position, 2 = request position, 3 = TCK position, 4 = hold count. For selectors 0..3, bits 2..0 give the new bit position (0..6); position 7 leaves the map unchanged. Selectors 5..7 have no effect.
- R7: With selector 4, bits 3..0 set the hold count H (default 2). After a write, `in_ready` stays low for H clocks, so the snapshot is held for H+1 clocks. Reads and configuration commands start no hold.
- R8: TDO is sampled through two flops. A TDO change made less than two clocks before a read is accepted is not seen by that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command byte valid |
| in_ready | output | 1 | Command byte accepted when high with in_valid |
| in_data | input | 8 | Command byte |
| out_valid | output | 1 | Response byte pending |
| out_ready | input | 1 | Response byte taken |
| out_data | output | 8 | Response byte, TDO in bit 2 |
| tdo | input | 1 | JTAG return line, asynchronous |
| tck | output | 1 | JTAG clock pin |
| tms | output | 1 | JTAG mode select pin |
| tdi | output | 1 | JTAG data pin to the target |

## Verification
The assertions check four properties on every cycle:
- the padding of the response byte;
- the single-pending rule with its stable response;
- that the pins never move without an accepted byte;
- that no response appears without an accepted byte.

The bench scenarios cover the remaining behaviour:
- the exact pin mapping;
- which TDO value a read reports;
- the length of the hold window;
- the effect of remapping and of the rejected position or selector codes.

// File: rtl/jtag_byte_driver.sv
module jtag_byte_driver #(
  parameter int DEF_HOLD = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  input  logic       tdo,
  output logic       tck,
  output logic       tms,
  output logic       tdi
);
  localparam int HOLD_W = 4;
  localparam int POS_W  = 3;
  localparam logic [POS_W-1:0] POS_NONE = POS_W'(7);

  logic [POS_W-1:0]  pos_tms, pos_tdi, pos_req, pos_tck;
  logic [HOLD_W-1:0] hold_q, hold_cnt;
  logic              tdo_m, tdo_s;
  logic              resp_pend, resp_bit;

  wire             take   = in_valid && in_ready;
  wire             is_cfg = in_data[7];
  wire             is_req = !is_cfg && in_data[pos_req];
  wire             is_wr  = !is_cfg && !in_data[pos_req];
  wire [2:0]       sel    = in_data[6:4];
  wire [POS_W-1:0] cpos   = in_data[2:0];
  wire             pos_ok = (cpos != POS_NONE);

  assign in_ready  = (hold_cnt == '0) && !resp_pend;
  assign out_valid = resp_pend;
  assign out_data  = {5'b0, resp_bit, 2'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tdo_m <= 1'b0;
      tdo_s <= 1'b0;
    end else begin
      tdo_m <= tdo;
      tdo_s <= tdo_m;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_tms <= POS_W'(0);
      pos_tdi <= POS_W'(1);
      pos_req <= POS_W'(2);
      pos_tck <= POS_W'(3);
      hold_q  <= HOLD_W'(DEF_HOLD);
    end else if (take && is_cfg) begin
      case (sel)
        3'd0: if (pos_ok) pos_tms <= cpos;
        3'd1: if (pos_ok) pos_tdi <= cpos;
        3'd2: if (pos_ok) pos_req <= cpos;
        3'd3: if (pos_ok) pos_tck <= cpos;
        3'd4: hold_q <= in_data[3:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tck      <= 1'b0;
      tms      <= 1'b1;
      tdi      <= 1'b0;
      hold_cnt <= '0;
    end else if (take && is_wr) begin
      tck      <= in_data[pos_tck];
      tms      <= in_data[pos_tms];
      tdi      <= in_data[pos_tdi];
      hold_cnt <= hold_q;
    end else if (hold_cnt != '0) begin
      hold_cnt <= hold_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_pend <= 1'b0;
      resp_bit  <= 1'b0;
    end else if (take && is_req) begin
      resp_pend <= 1'b1;
      resp_bit  <= tdo_s;
    end else if (out_ready) begin
      resp_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/jtag_byte_driver_chk.sv
module jtag_byte_driver_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       tck,
  input logic       tms,
  input logic       tdi
);
  AST_RESP_PADDING: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_data & 8'hFB) == 8'h00)); // R3

  AST_RESP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready)); // R3

  AST_SINGLE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R4

  AST_RESP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R4

  AST_PINS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable({tck, tms, tdi})); // R2
endmodule

bind jtag_byte_driver jtag_byte_driver_chk u_chk (.*);

// File: tb/jtag_byte_driver_tb.sv
module jtag_byte_driver_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_data;
  logic       tdo = 1'b0;
  logic       tck, tms, tdi;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  jtag_byte_driver u_dut (.*);

  // [15:8] command, [7] tdo level, [6:4] expected {tck,tms,tdi}, [3] read
  localparam logic [15:0] VEC [0:11] = '{
    16'h0000, 16'h0960, 16'h0210, 16'h0B70, 16'h04F8, 16'h0F78,
    16'h7000, 16'h0840, 16'h0CC8, 16'h7B70, 16'h0120, 16'h0628
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic get_resp(output logic [7:0] r);
    @(negedge clk);
    while (!out_valid) @(negedge clk);
    r = out_data;
    out_ready = 1'b1;
    @(posedge clk);
    #1 out_ready = 1'b0;
  endtask

  task automatic set_tdo(input logic v);
    @(negedge clk);
    tdo = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check({tck, tms, tdi} == 3'b010, "R1 pins", {tck, tms, tdi}, 3'b010);
    check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);

    // R2 R3 R5: interleaved table walk
    for (int i = 0; i < 12; i++) begin
      set_tdo(VEC[i][7]);
      send(VEC[i][15:8]);
      if (VEC[i][3]) begin
        get_resp(r);
        check(r == {5'b0, VEC[i][7], 2'b0}, "R3 R5 response", r, {5'b0, VEC[i][7], 2'b0});
      end else begin
        @(negedge clk);
        check(out_valid == 1'b0, "R2 no response on write", out_valid, 0);
      end
      check({tck, tms, tdi} == VEC[i][6:4], "R2 R5 pins", {tck, tms, tdi}, VEC[i][6:4]);
    end

    // R4: pending response blocks input
    set_tdo(1'b1);
    send(8'h04);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 8'h08;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(in_ready == 1'b0 && out_valid == 1'b1, "R4 blocked", {in_ready, out_valid}, 2'b01);
      check(out_data == 8'h04, "R4 data held", out_data, 8'h04);
      check({tck, tms, tdi} == 3'b010, "R4 pins unchanged", {tck, tms, tdi}, 3'b010);
    end
    out_ready = 1'b1;
    @(posedge clk);
    #1 out_ready = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1, "R4 ready after take", in_ready, 1);
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    check({tck, tms, tdi} == 3'b100, "R4 queued write applied", {tck, tms, tdi}, 3'b100);

    // R7: default hold of 2
    send(8'h01);
    n = 0;
    @(negedge clk);
    while (!in_ready) begin
      n++;
      check({tck, tms, tdi} == 3'b010, "R7 pins held", {tck, tms, tdi}, 3'b010);
      @(negedge clk);
    end
    check(n == 2, "R7 default hold", n, 2);

    // R7: hold of 5
    send(8'hC5);
    @(negedge clk);
    check(in_ready == 1'b1, "R7 config starts no hold", in_ready, 1);
    send(8'h08);
    n = 0;
    @(negedge clk);
    while (!in_ready) begin
      n++;
      @(negedge clk);
    end
    check(n == 5, "R7 hold five", n, 5);

    // R7: hold of 0
    send(8'hC0);
    send(8'h02);
    @(negedge clk);
    check(in_ready == 1'b1, "R7 hold zero", in_ready, 1);
    send(8'hC2);

    // R6: remap TCK to bit 5, REQ to bit 6
    send(8'hB5);
    send(8'h20);
    @(negedge clk);
    check({tck, tms, tdi} == 3'b100, "R6 tck at bit5", {tck, tms, tdi}, 3'b100);
    send(8'h08);
    @(negedge clk);
    check({tck, tms, tdi} == 3'b000, "R6 old tck bit ignored", {tck, tms, tdi}, 3'b000);
    send(8'hA6);
    send(8'h05);
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R6 old req bit is write", out_valid, 0);
    check({tck, tms, tdi} == 3'b010, "R6 old req bit pins", {tck, tms, tdi}, 3'b010);
    set_tdo(1'b1);
    send(8'h40);
    get_resp(r);
    check(r == 8'h04, "R6 req at bit6", r, 8'h04);
    send(8'h87);
    send(8'hD3);
    send(8'h00);
    send(8'h01);
    @(negedge clk);
    check({tms, tck} == 2'b10, "R6 position 7 and selector 5 ignored", {tms, tck}, 2'b10);
    send(8'hB3);
    send(8'hA2);
    send(8'h08);
    @(negedge clk);
    check({tck, tms, tdi} == 3'b100, "R6 restored map", {tck, tms, tdi}, 3'b100);

    // R8: late TDO change not seen
    set_tdo(1'b0);
    @(negedge clk);
    tdo = 1'b1;
    in_valid = 1'b1;
    in_data = 8'h04;
    @(posedge clk);
    #1 in_valid = 1'b0;
    get_resp(r);
    check(r == 8'h00, "R8 late change hidden", r, 8'h00);
    repeat (3) @(negedge clk);
    send(8'h04);
    get_resp(r);
    check(r == 8'h04, "R8 settled value seen", r, 8'h04);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule